// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside the instruction fetch logic of an 8-bit processor core. At each instruction boundary it decides whether control passes to an interrupt handler, and if so it drives the bus cycles of the handler entry. There are two causes of entry. The first is a hardware request from one of three lines: a timer line and two external lines. The second is the software break instruction, which the decoder reports on `brk_req`. During the entry the block issues its own reads and writes, pulses a stack pointer decrement for every push, writes the updated status byte back and loads a new program counter from a vector.

The request lines are sampled into a register on every clock, and one clock is one bus cycle. While the interrupt-disable flag is set, the sample is forced to zero. When an entry starts, the block captures the program counter, status byte and stack pointer. From then on it works only from these copies. The `done` pulse appears in the cycle where the new program counter is presented, so the fetch logic can resume on the next cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, `bus_rd`, `bus_wr`, `pc_we`, `status_we`, `sp_dec` and `done` are all 0.
- R2: The request lines are sampled on every clock edge. A sample taken while status bit 2 (interrupt disable) is 1 counts as no request. A boundary after such a sample, with no break, starts no entry.
- R3: A hardware entry chooses its vector by fixed priority: timer at 0xFFFA, then external line 1 at 0xFFF8, then external line 2 at 0xFFF6.
- R4: A break entry always uses vector 0xFFF6, whatever requests are pending, and it enters even when nothing is pending.
- R5: A hardware entry takes 10 bus cycles, in this order: three reads at the captured PC, a write of PC[15:8], a write of PC[7:0], two reads at the captured PC, a write of the status byte, a read at the vector, and a read at the vector plus one. A break entry omits the first two reads and takes 8 cycles. PC is never incremented.
- R6: The status byte pushed by a break has bit 4 set. The one pushed by a hardware entry has bit 4 cleared. All other bits are pushed as captured, including bit 3 (decimal) and bit 5 (memory-mode).
- R7: In the status push cycle, `status_we` is 1 and `status_out` is the captured status with bits 3 and 5 cleared and bit 2 set.
- R8: Each push writes to address 0x2100 + SP and pulses `sp_dec` in that same cycle. SP is 8 bits and wraps from 0x00 to 0xFF.
- R9: In the last cycle, `pc_we` and `done` are 1 and `pc_out` = {byte read at vector+1, byte read at vector}. In the following cycle `busy` is 0.
- R10: A boundary with no pending sample and no break leaves the bus idle and `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_timer | input | 1 | Timer request line (highest priority) |
| req_ext1 | input | 1 | External request line 1 |
| req_ext2 | input | 1 | External request line 2 (lowest priority) |
| boundary | input | 1 | Instruction boundary strobe |
| brk_req | input | 1 | Break instruction at this boundary |
| pc_in | input | 16 | Program counter to push |
| status_in | input | 8 | Current status byte |
| sp_in | input | 8 | Current stack pointer |
| bus_rdata | input | 8 | Read data, valid in the same cycle |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| sp_dec | output | 1 | Stack pointer decrement pulse |
| status_out | output | 8 | New status byte |
| status_we | output | 1 | Status write enable |
| pc_out | output | 16 | New program counter |
| pc_we | output | 1 | Program counter load enable |
| done | output | 1 | Entry complete pulse |
| busy | output | 1 | Entry in progress |

## Verification
The sweep covers all eight combinations of the three request lines. Each combination is tried with the disable flag clear and set, and with and without a break, which gives 32 entries. Clear-flag hardware cases separate the three priority levels from one another. Set-flag cases separate masking from priority, and break cases show that the vector is fixed and that the two leading reads are dropped. Varied status patterns separate the pushed byte from the written-back byte, and stack pointers of 0x00 and 0x01 expose wrap errors in the push addresses.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_DUMA, ST_DUMB, ST_DUMC, ST_PSH_H, ST_PSH_L,
      ST_DUMD, ST_DUME, ST_PSH_P, ST_VEC_L, ST_VEC_H
   } entry_state_t;

   localparam int FLAG_I = 2;
   localparam int FLAG_D = 3;
   localparam int FLAG_B = 4;
   localparam int FLAG_T = 5;
   localparam int NUM_SRC = 3;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
   parameter int ADDR_W = 16,
   parameter bit SAMPLE_REG = 1'b1,
   parameter logic [ADDR_W-1:0] VEC_TIMER = 16'hFFFA,
   parameter logic [ADDR_W-1:0] VEC_EXT1 = 16'hFFF8,
   parameter logic [ADDR_W-1:0] VEC_EXT2 = 16'hFFF6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic [irq_entry_pkg::NUM_SRC-1:0] req,
   input  logic mask,
   output logic any_pend,
   output logic [ADDR_W-1:0] vec_sel
);
   localparam int N = irq_entry_pkg::NUM_SRC;
   logic [N-1:0] pend;

   generate
      if (SAMPLE_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend <= '0;
            else        pend <= mask ? '0 : req;
         end
      end else begin : g_comb
         assign pend = mask ? '0 : req;
      end
   endgenerate

   assign any_pend = |pend;

   always_comb begin
      if (pend[2])      vec_sel = VEC_TIMER;
      else if (pend[1]) vec_sel = VEC_EXT1;
      else              vec_sel = VEC_EXT2;
   end
endmodule

// File: rtl/entry_fsm.sv
module entry_fsm #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] STACK_BASE = 16'h2100,
   parameter logic [ADDR_W-1:0] VEC_BRK = 16'hFFF6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic boundary,
   input  logic brk_req,
   input  logic any_pend,
   input  logic [ADDR_W-1:0] vec_sel,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] status_in,
   input  logic [7:0] sp_in,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic bus_rd,
   output logic bus_wr,
   output logic sp_dec,
   output logic [DATA_W-1:0] status_out,
   output logic status_we,
   output logic [ADDR_W-1:0] pc_out,
   output logic pc_we,
   output logic done,
   output logic busy
);
   import irq_entry_pkg::*;
   localparam int HALF = ADDR_W / 2;
   localparam logic [DATA_W-1:0] B_MASK = DATA_W'(1) << FLAG_B;
   localparam logic [DATA_W-1:0] DT_MASK = (DATA_W'(1) << FLAG_D) | (DATA_W'(1) << FLAG_T);
   localparam logic [DATA_W-1:0] I_MASK = DATA_W'(1) << FLAG_I;

   entry_state_t state, nxt;
   logic [ADDR_W-1:0] pc_q, vec_q;
   logic [DATA_W-1:0] p_q, lo_q;
   logic [7:0] sp_q;
   logic brk_q;
   logic [ADDR_W-1:0] stack_addr;

   assign stack_addr = STACK_BASE + {{(ADDR_W-8){1'b0}}, sp_q};

   always_comb begin
      case (state)
         ST_DUMA:  nxt = ST_DUMB;
         ST_DUMB:  nxt = ST_DUMC;
         ST_DUMC:  nxt = ST_PSH_H;
         ST_PSH_H: nxt = ST_PSH_L;
         ST_PSH_L: nxt = ST_DUMD;
         ST_DUMD:  nxt = ST_DUME;
         ST_DUME:  nxt = ST_PSH_P;
         ST_PSH_P: nxt = ST_VEC_L;
         ST_VEC_L: nxt = ST_VEC_H;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         pc_q  <= '0;
         vec_q <= '0;
         p_q   <= '0;
         lo_q  <= '0;
         sp_q  <= '0;
         brk_q <= 1'b0;
      end else if (state == ST_IDLE) begin
         if (boundary && (brk_req || any_pend)) begin
            state <= brk_req ? ST_DUMC : ST_DUMA;
            vec_q <= brk_req ? VEC_BRK : vec_sel;
            brk_q <= brk_req;
            pc_q  <= pc_in;
            p_q   <= status_in;
            sp_q  <= sp_in;
         end
      end else begin
         state <= nxt;
         if (sp_dec) sp_q <= sp_q - 8'd1;
         if (state == ST_VEC_L) lo_q <= bus_rdata;
      end
   end

   always_comb begin
      bus_addr   = pc_q;
      bus_wdata  = '0;
      bus_rd     = 1'b0;
      bus_wr     = 1'b0;
      sp_dec     = 1'b0;
      status_out = (p_q & ~DT_MASK) | I_MASK;
      status_we  = 1'b0;
      pc_out     = {bus_rdata, lo_q};
      pc_we      = 1'b0;
      done       = 1'b0;
      case (state)
         ST_DUMA, ST_DUMB, ST_DUMC, ST_DUMD, ST_DUME: bus_rd = 1'b1;
         ST_PSH_H: begin
            bus_wr = 1'b1; sp_dec = 1'b1; bus_addr = stack_addr;
            bus_wdata = pc_q[ADDR_W-1:HALF];
         end
         ST_PSH_L: begin
            bus_wr = 1'b1; sp_dec = 1'b1; bus_addr = stack_addr;
            bus_wdata = pc_q[HALF-1:0];
         end
         ST_PSH_P: begin
            bus_wr = 1'b1; sp_dec = 1'b1; bus_addr = stack_addr;
            bus_wdata = brk_q ? (p_q | B_MASK) : (p_q & ~B_MASK);
            status_we = 1'b1;
         end
         ST_VEC_L: begin bus_rd = 1'b1; bus_addr = vec_q; end
         ST_VEC_H: begin
            bus_rd = 1'b1; bus_addr = vec_q + 1'b1;
            pc_we = 1'b1; done = 1'b1;
         end
         default: ;
      endcase
   end

   assign busy = (state != ST_IDLE);

   // R5
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bus_rd, bus_wr}));
   // R8
   push_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |-> bus_addr[ADDR_W-1:8] == STACK_BASE[ADDR_W-1:8]);
   // R8
   sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sp_dec |=> (sp_q == $past(sp_q) - 8'd1));
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   // R10
   no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && boundary && !brk_req && !any_pend) |=> !busy);
   // R6
   brk_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_we && bus_wr) |-> (bus_wdata[FLAG_B] == brk_q));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter bit SAMPLE_REG = 1'b1,
   parameter logic [ADDR_W-1:0] STACK_BASE = 16'h2100,
   parameter logic [ADDR_W-1:0] VEC_TIMER = 16'hFFFA,
   parameter logic [ADDR_W-1:0] VEC_EXT1 = 16'hFFF8,
   parameter logic [ADDR_W-1:0] VEC_EXT2 = 16'hFFF6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_timer,
   input  logic req_ext1,
   input  logic req_ext2,
   input  logic boundary,
   input  logic brk_req,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] status_in,
   input  logic [7:0] sp_in,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic bus_rd,
   output logic bus_wr,
   output logic sp_dec,
   output logic [DATA_W-1:0] status_out,
   output logic status_we,
   output logic [ADDR_W-1:0] pc_out,
   output logic pc_we,
   output logic done,
   output logic busy
);
   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("irq_entry_seq: DATA_W must be 8");
      end
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
         $error("irq_entry_seq: ADDR_W must be twice DATA_W");
      end
   endgenerate

   logic any_pend;
   logic [ADDR_W-1:0] vec_sel;

   irq_arbiter #(
      .ADDR_W(ADDR_W), .SAMPLE_REG(SAMPLE_REG),
      .VEC_TIMER(VEC_TIMER), .VEC_EXT1(VEC_EXT1), .VEC_EXT2(VEC_EXT2)
   ) u_arb (
      .clk(clk), .rst_n(rst_n),
      .req({req_timer, req_ext1, req_ext2}),
      .mask(status_in[irq_entry_pkg::FLAG_I]),
      .any_pend(any_pend), .vec_sel(vec_sel)
   );

   entry_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .STACK_BASE(STACK_BASE), .VEC_BRK(VEC_EXT2)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .boundary(boundary), .brk_req(brk_req),
      .any_pend(any_pend), .vec_sel(vec_sel), .pc_in(pc_in),
      .status_in(status_in), .sp_in(sp_in), .bus_rdata(bus_rdata),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .sp_dec(sp_dec), .status_out(status_out),
      .status_we(status_we), .pc_out(pc_out), .pc_we(pc_we),
      .done(done), .busy(busy)
   );
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_timer = 0, req_ext1 = 0, req_ext2 = 0, boundary = 0, brk_req = 0;
   logic [15:0] pc_in = '0;
   logic [7:0] status_in = '0, sp_in = '0, bus_rdata;
   logic [15:0] bus_addr, pc_out;
   logic [7:0] bus_wdata, status_out;
   logic bus_rd, bus_wr, sp_dec, status_we, pc_we, done, busy;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   assign bus_rdata = mem_byte(bus_addr);

   irq_entry_seq u_irq_entry_seq (
      .clk(clk), .rst_n(rst_n), .req_timer(req_timer), .req_ext1(req_ext1),
      .req_ext2(req_ext2), .boundary(boundary), .brk_req(brk_req),
      .pc_in(pc_in), .status_in(status_in), .sp_in(sp_in),
      .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .sp_dec(sp_dec),
      .status_out(status_out), .status_we(status_we), .pc_out(pc_out),
      .pc_we(pc_we), .done(done), .busy(busy)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_case(input bit t, input bit e1, input bit e2, input bit ibit,
                           input bit brk, input logic [7:0] sp, input logic [15:0] pc,
                           input logic [7:0] pbase);
      logic [7:0] p;
      logic [15:0] vec;
      logic [15:0] ea[10];
      logic ew[10];
      logic [7:0] ed[10];
      int n;
      bit enter;
      p = ibit ? (pbase | 8'h04) : (pbase & 8'hFB);
      enter = brk || (!ibit && (t || e1 || e2));
      if (brk) vec = 16'hFFF6;
      else if (t) vec = 16'hFFFA;
      else if (e1) vec = 16'hFFF8;
      else vec = 16'hFFF6;
      n = 0;
      if (!brk) begin
         ea[0] = pc; ew[0] = 0; ed[0] = 0;
         ea[1] = pc; ew[1] = 0; ed[1] = 0;
         n = 2;
      end
      ea[n] = pc; ew[n] = 0; ed[n] = 0; n++;
      ea[n] = 16'h2100 + {8'h00, sp}; ew[n] = 1; ed[n] = pc[15:8]; n++;
      ea[n] = 16'h2100 + {8'h00, 8'(sp - 8'd1)}; ew[n] = 1; ed[n] = pc[7:0]; n++;
      ea[n] = pc; ew[n] = 0; ed[n] = 0; n++;
      ea[n] = pc; ew[n] = 0; ed[n] = 0; n++;
      ea[n] = 16'h2100 + {8'h00, 8'(sp - 8'd2)}; ew[n] = 1;
      ed[n] = brk ? (p | 8'h10) : (p & 8'hEF); n++;
      ea[n] = vec; ew[n] = 0; ed[n] = 0; n++;
      ea[n] = vec + 16'd1; ew[n] = 0; ed[n] = 0; n++;

      @(negedge clk);
      req_timer = t; req_ext1 = e1; req_ext2 = e2;
      status_in = p; sp_in = sp; pc_in = pc;
      @(negedge clk);
      boundary = 1'b1; brk_req = brk;
      @(negedge clk);
      boundary = 1'b0; brk_req = 1'b0;
      if (!enter) begin
         for (int k = 0; k < 3; k++) begin
            // R10 / R2: no entry, bus idle
            chk(ibit ? "R2" : "R10", {busy, bus_rd, bus_wr}, 3'b000);
            @(negedge clk);
         end
      end else begin
         for (int k = 0; k < n; k++) begin
            // R5 cycle order and addresses, R3/R4 vector addresses
            chk(k >= n - 2 ? (brk ? "R4" : "R3") : "R5",
                {bus_rd, bus_wr, bus_addr}, {!ew[k], ew[k], ea[k]});
            // R8 decrement pulse on each push
            chk("R8", sp_dec, ew[k]);
            if (ew[k]) chk(k == n - 3 ? "R6" : "R5", bus_wdata, ed[k]);
            if (k == n - 3) chk("R7", {status_we, status_out}, {1'b1, (p & 8'hD7) | 8'h04});
            if (k == n - 1) begin
               chk("R9", {pc_we, done, pc_out},
                   {2'b11, mem_byte(vec + 16'd1), mem_byte(vec)});
            end
            @(negedge clk);
         end
         chk("R9", busy, 1'b0);
      end
      req_timer = 0; req_ext1 = 0; req_ext2 = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", {busy, bus_rd, bus_wr, pc_we, status_we, sp_dec, done}, 7'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {busy, bus_rd, bus_wr, pc_we, status_we, sp_dec, done}, 7'b0);
      for (int idx = 0; idx < 32; idx++) begin
         run_case(idx[2], idx[1], idx[0], idx[3], idx[4],
                  8'hF0 - 8'(idx), 16'h8000 + 16'(idx * 16'h0123),
                  8'(idx * 8'h2D) ^ 8'hA8);
      end
      // R8 stack pointer wrap
      run_case(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 16'h4321, 8'h28);
      run_case(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 16'hC0DE, 8'hE9);
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule